// File: doc/BRIEF.md
# Phase-Shifted Variable-Frequency PWM Generator

This block makes one PWM waveform whose period, phase offset and duty can all be changed while it is running. A free-running master counter sets the period. When it reaches a programmable phase point, it sends out a single-cycle trigger. A one-shot slave counter restarts on each trigger, runs for exactly one period and drives the PWM output from its own count. The output edges are therefore shifted from the master's period boundary by the phase value.

The period, phase and duty inputs are captured into one active set only at master period boundaries, and continuously while the block is idle. A change written in the middle of a cycle therefore never produces a truncated or stretched pulse. A phase value at or above the period makes the trigger impossible, so the output stays at its idle level. A period of zero turns the block off.

Top module: `pwm_phase_gen`

## Requirements
- R1: While running, the master counter steps 0, 1, ..., P and wraps to 0, where P is the active period. `wrap_o` is high for one cycle when the count equals P, so boundaries are P+1 cycles apart.
- R2: `trig_o` is a single-cycle pulse, high only in the cycle where the master count equals the active phase value and that value is below the active period.
- R3: A trigger restarts the slave: on the next cycle its count is 0 and it is active. It then counts up to the active period and stops unless triggered again.
- R4: If the active phase value is greater than or equal to the active period, no trigger occurs and `pwm_o` stays at its idle level.
- R5: Period, phase and duty take new input values only at the clock edge that ends a cycle with `wrap_o` high, or on any edge while the block is not running. All three change together.
- R6: `pol_i`=0: `pwm_o` is high while the slave is active and its count is below the active duty value, otherwise low. `pol_i`=1 gives the exact inverse.
- R7: During reset or while `en_i` is low, both counters are held at 0, `trig_o` and `wrap_o` are low, and `pwm_o` equals `pol_i` (its idle level).
- R8: An active period of 0 keeps the block idle, as in R7. A period of 1 gives a 2-cycle period.
- R9: A trigger that arrives while the slave is still running restarts it from 0 on that same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable |
| period_i | input | CNT_W | Period value P (cycle length P+1) |
| phase_i | input | CNT_W | Master count at which the slave is triggered |
| duty_i | input | CNT_W | Slave count at which the output changes level |
| pol_i | input | 1 | Polarity: 0 high-first, 1 low-first |
| pwm_o | output | 1 | PWM output |
| trig_o | output | 1 | Master trigger pulse |
| wrap_o | output | 1 | Period-boundary strobe |

## Verification
The hardest case to reach is a retrigger in the middle of a slave run. In steady state every trigger lands exactly as the slave finishes its period, so restarts always look seamless. To force an early restart, the bench lowers the phase value during a cycle. The new, smaller phase is loaded at the next boundary, and it fires while the slave is still partway through a run that was started from the old, larger phase. The bench also shortens the period with phase and duty changes pending in the same write. This checks that all three values switch together, on the exact wrap edge.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic {
    POL_HIGH_FIRST = 1'b0,
    POL_LOW_FIRST  = 1'b1
  } pwm_pol_e;

  typedef struct packed {
    logic run;
    logic load;
  } pwm_ctl_t;
endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] per_d_i,
  input  logic [CNT_W-1:0] ph_d_i,
  input  logic [CNT_W-1:0] du_d_i,
  output logic [CNT_W-1:0] per_q_o,
  output logic [CNT_W-1:0] ph_q_o,
  output logic [CNT_W-1:0] du_q_o
);
  logic [CNT_W-1:0] per_q, ph_q, du_q;
  logic [CNT_W-1:0] per_n, ph_n, du_n;

  always_comb begin
    per_n = per_q;
    ph_n  = ph_q;
    du_n  = du_q;
    if (load_i) begin
      per_n = per_d_i;
      ph_n  = ph_d_i;
      du_n  = du_d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= '0;
      ph_q  <= '0;
      du_q  <= '0;
    end else begin
      per_q <= per_n;
      ph_q  <= ph_n;
      du_q  <= du_n;
    end
  end

  assign per_q_o = per_q;
  assign ph_q_o  = ph_q;
  assign du_q_o  = du_q;
endmodule

// File: rtl/pwm_master_cnt.sv
module pwm_master_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] ph_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             trig_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             at_end;
  logic             ph_valid;

  assign at_end   = (cnt_q == per_i);
  assign ph_valid = (ph_i < per_i);

  always_comb begin
    cnt_n = cnt_q;
    if (!run_i) begin
      cnt_n = '0;
    end else if (at_end) begin
      cnt_n = '0;
    end else begin
      cnt_n = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = run_i && at_end;
  assign trig_o = run_i && ph_valid && (cnt_q == ph_i);
endmodule

// File: rtl/pwm_slave_oneshot.sv
module pwm_slave_oneshot #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             pol_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             act_o,
  output logic             pwm_o
);
  import pwm_pkg::*;

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             act_q, act_n;
  logic             level_hi;
  pwm_pol_e         pol;

  always_comb begin
    cnt_n = cnt_q;
    act_n = act_q;
    if (!run_i) begin
      cnt_n = '0;
      act_n = 1'b0;
    end else if (trig_i) begin
      cnt_n = '0;
      act_n = 1'b1;
    end else if (act_q) begin
      if (cnt_q == per_i) begin
        act_n = 1'b0;
      end else begin
        cnt_n = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      act_q <= act_n;
    end
  end

  assign pol      = pwm_pol_e'(pol_i);
  assign level_hi = run_i && act_q && (cnt_q < duty_i);

  always_comb begin
    if (pol == POL_HIGH_FIRST) pwm_o = level_hi;
    else                       pwm_o = !level_hi;
  end

  assign cnt_o = cnt_q;
  assign act_o = act_q;
endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             pol_i,
  output logic             pwm_o,
  output logic             trig_o,
  output logic             wrap_o
);
  import pwm_pkg::*;

  logic [CNT_W-1:0] per_a, ph_a, du_a;
  logic [CNT_W-1:0] mcnt, scnt;
  logic             sact;
  logic             trig, wrap;
  pwm_ctl_t         ctl;

  assign ctl.run  = en_i && (per_a != '0);
  assign ctl.load = !ctl.run || wrap;

  pwm_shadow_regs #(.CNT_W(CNT_W)) u_shadow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (ctl.load),
    .per_d_i (period_i),
    .ph_d_i  (phase_i),
    .du_d_i  (duty_i),
    .per_q_o (per_a),
    .ph_q_o  (ph_a),
    .du_q_o  (du_a)
  );

  pwm_master_cnt #(.CNT_W(CNT_W)) u_master (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ctl.run),
    .per_i  (per_a),
    .ph_i   (ph_a),
    .cnt_o  (mcnt),
    .trig_o (trig),
    .wrap_o (wrap)
  );

  pwm_slave_oneshot #(.CNT_W(CNT_W)) u_slave (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ctl.run),
    .trig_i (trig),
    .per_i  (per_a),
    .duty_i (du_a),
    .pol_i  (pol_i),
    .cnt_o  (scnt),
    .act_o  (sact),
    .pwm_o  (pwm_o)
  );

  assign trig_o = trig;
  assign wrap_o = wrap;
endmodule

// File: rtl/pwm_phase_gen_chk.sv
module pwm_phase_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             pol_i,
  input logic             pwm_o,
  input logic             trig_o,
  input logic             wrap_o,
  input logic [CNT_W-1:0] per_a,
  input logic [CNT_W-1:0] ph_a,
  input logic [CNT_W-1:0] mcnt,
  input logic [CNT_W-1:0] scnt,
  input logic             sact
);
  a_r2_trig_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  a_r1_wrap_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> !wrap_o);

  a_r1_wrap_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (mcnt == '0));

  a_r3_trig_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> (sact && scnt == '0));

  a_r4_no_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_a >= per_a) |-> !trig_o);

  a_r5_hold_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && per_a != '0 && !wrap_o) |=> $stable(per_a) && $stable(ph_a));

  a_r7_idle_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!trig_o && !wrap_o && pwm_o == pol_i));

  a_r8_zero_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_a == '0) |-> (!trig_o && !wrap_o));
endmodule

bind pwm_phase_gen pwm_phase_gen_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .pol_i  (pol_i),
  .pwm_o  (pwm_o),
  .trig_o (trig_o),
  .wrap_o (wrap_o),
  .per_a  (per_a),
  .ph_a   (ph_a),
  .mcnt   (mcnt),
  .scnt   (scnt),
  .sact   (sact)
);

// File: tb/pwm_phase_gen_tb.sv
module pwm_phase_gen_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         en;
  logic [W-1:0] per, ph, du;
  logic         pol;
  logic         pwm, trig, wrap;

  int n_cmp = 0;
  int n_bad = 0;
  int n_trig = 0;
  int n_wrap = 0;
  int last_wrap = -1;
  int wrap_gap = 0;
  int cyc = 0;
  bit done = 0;

  // behavioural reference state
  int m_cnt, s_cnt, a_per, a_ph, a_du;
  bit s_act;

  always #2.5 clk = ~clk;

  pwm_phase_gen #(.CNT_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .period_i(per), .phase_i(ph), .duty_i(du), .pol_i(pol),
    .pwm_o(pwm), .trig_o(trig), .wrap_o(wrap)
  );

  function automatic bit m_run();
    return en && (a_per != 0);
  endfunction
  function automatic bit e_trig();
    return m_run() && (m_cnt == a_ph) && (a_ph < a_per);
  endfunction
  function automatic bit e_wrap();
    return m_run() && (m_cnt == a_per);
  endfunction
  function automatic bit e_pwm();
    bit hi;
    hi = m_run() && s_act && (s_cnt < a_du);
    return pol ? !hi : hi;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; s_cnt = 0; s_act = 0; a_per = 0; a_ph = 0; a_du = 0;
    end else begin
      bit t, w;
      t = e_trig();
      w = e_wrap();
      if (!m_run()) begin
        m_cnt = 0; s_cnt = 0; s_act = 0;
        a_per = int'(per); a_ph = int'(ph); a_du = int'(du);
      end else begin
        if (t) begin s_cnt = 0; s_act = 1; end
        else if (s_act) begin
          if (s_cnt == a_per) s_act = 0; else s_cnt++;
        end
        if (w) begin
          m_cnt = 0;
          a_per = int'(per); a_ph = int'(ph); a_du = int'(du);
        end else m_cnt++;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the reference, sampled at the falling edge
  always @(negedge clk) begin
    if (!done) begin
      cyc++;
      chk("R2", "trig_o", int'(trig), int'(e_trig()));
      chk("R1", "wrap_o", int'(wrap), int'(e_wrap()));
      chk("R6", "pwm_o", int'(pwm), int'(e_pwm()));
      if (trig) n_trig++;
      if (wrap) begin
        n_wrap++;
        if (last_wrap >= 0) wrap_gap = cyc - last_wrap;
        last_wrap = cyc;
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clr_stats();
    n_trig = 0; n_wrap = 0; last_wrap = -1; wrap_gap = 0;
  endtask

  task automatic summary();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; per = '0; ph = '0; du = '0; pol = 1'b0;
    step(3);
    // R7: outputs during reset
    chk("R7", "reset pwm", int'(pwm), 0);
    chk("R7", "reset trig", int'(trig), 0);
    rst_n = 1'b1;
    step(2);

    // R1/R6: P=9, phase 3, duty 5, high-first
    per = 9; ph = 3; du = 5; en = 1'b1;
    clr_stats();
    step(60);
    chk("R1", "wrap spacing P=9", wrap_gap, 10);
    chk("R2", "trigs per period", n_trig, 6);

    // R6: inverse polarity
    pol = 1'b1;
    step(30);
    pol = 1'b0;

    // R5: shorten period mid-cycle, duty and phase follow at the boundary
    step(4);
    per = 5; du = 3; ph = 2;
    clr_stats();
    step(40);
    chk("R5", "wrap spacing after change", wrap_gap, 6);

    // R9: lower the phase so the new trigger lands in a running slave
    per = 11; ph = 9; du = 6;
    step(30);
    ph = 1;
    step(40);

    // R4: phase at/above period, output idle
    ph = 11;
    step(15);
    clr_stats();
    step(40);
    chk("R4", "trig count phase=period", n_trig, 0);
    chk("R4", "pwm idle", int'(pwm), 0);
    ph = 14;
    pol = 1'b1;
    step(30);
    chk("R4", "pwm idle inverse", int'(pwm), 1);
    pol = 1'b0;

    // R8: period 1, two-cycle period
    per = 1; ph = 0; du = 1;
    step(20);
    clr_stats();
    step(20);
    chk("R8", "wrap spacing P=1", wrap_gap, 2);
    chk("R8", "wrap count P=1", n_wrap, 10);

    // R8: period 0 disables
    per = 0;
    step(5);
    clr_stats();
    step(20);
    chk("R8", "no wrap at P=0", n_wrap, 0);

    // R7: enable low mid-run
    per = 7; ph = 2; du = 4;
    step(25);
    en = 1'b0;
    clr_stats();
    step(20);
    chk("R7", "no trig disabled", n_trig, 0);
    chk("R7", "pwm idle disabled", int'(pwm), 0);
    en = 1'b1;
    step(30);

    // R3: slave runs one period then stops after phase goes invalid
    ph = 20;
    step(40);
    chk("R3", "slave stopped pwm", int'(pwm), 0);

    summary();
  end
endmodule